// File: doc/BRIEF.md
# Sample-Delayed Event Marker

This block tags an output sample stream with the arrival of an external timing event. The event input is asynchronous. It is brought into the clock domain through a short chain of flops, and a rising edge on the synchronized level arms a sample counter. The counter advances once per output-sample strobe and does not advance on clock cycles. When it runs out, the marker bit is raised in the status byte of exactly one output word.

Software writes the number of samples to wait into a configuration register. The intended setting is the group delay of the filter chain upstream. With that setting, the flagged word is the one that was being measured when the event arrived. The remaining status bits and the sample strobe flow through one register stage, which keeps the marker aligned with its word.

Top module: `evt_marker_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `vld_out` and `stat_out` are all zero. Reset clears the delay register to 0 and discards any pending marker.
- R2: The event input passes through a two-flop synchronizer, and only a rising edge of the synchronized level starts a count. Holding the input high, or taking it low, produces no further marker.
- R3: With a delay value N, the marker appears on the (N+1)th sample strobe that follows edge detection. With N = 0 this is the next strobe.
- R4: Each detected edge marks exactly one output word. The marker is clear on every later word until another rising edge occurs.
- R5: A write with `cfg_we` high and `cfg_addr` equal to 0x29 loads `cfg_wdata` (16 bits) into the delay register. A write to any other address leaves the delay unchanged.
- R6: A rising edge that arrives while a count is pending restarts the count from the current delay value. The earlier event is then never marked.
- R7: `vld_out` follows `smp_valid` one cycle later. `stat_out[6:0]` carries the registered `stat_in[6:0]`. `stat_out[7]` is the marker alone, and `stat_in[7]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous timing event input |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| smp_valid | input | 1 | Strobe marking one output sample word |
| stat_in | input | 8 | Status byte of the current sample |
| vld_out | output | 1 | Registered sample strobe |
| stat_out | output | 8 | Registered status byte, marker in bit 7 |

## Verification
A counter that loads the wrong value or decrements on clock cycles shows up as a marker on the wrong strobe index. The bench counts each strobe after an event, so the fault is visible on the first marked word, within N+1 samples. An armed flag that fails to clear gives a second marker on the very next strobe. An edge detector that also reacts to levels gives extra markers while the input is held high. A broken address decode moves the marker to an index taken from the stray write. Every one of these faults appears in the same event window in which the bad state arises.

// File: rtl/evt_marker_pkg.sv
package evt_marker_pkg;
  localparam int DLY_W       = 16;
  localparam int ADDR_W      = 8;
  localparam int STAT_W      = 8;
  localparam int MARK_BIT    = 7;
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] DLY_ADDR = 8'h29;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_lvl <= 1'b0;
    else     last_lvl <= chain[STAGES-1];
  end

  assign edge_pulse = chain[STAGES-1] & ~last_lvl;
endmodule

// File: rtl/dly_cfg.sv
module dly_cfg #(
  parameter int ADDR_W = 8,
  parameter int DLY_W  = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DLY_W-1:0]  wdata,
  output logic [DLY_W-1:0]  dly_q
);
  logic hit_addr;
  assign hit_addr = we && (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           dly_q <= '0;
    else if (hit_addr) dly_q <= wdata;
  end
endmodule

// File: rtl/dly_counter.sv
module dly_counter #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_pulse,
  input  logic             strobe,
  input  logic [DLY_W-1:0] dly,
  output logic             hit
);
  logic [DLY_W-1:0] remain;
  logic             armed;
  logic             at_zero;

  assign at_zero = (remain == '0);
  assign hit     = strobe & armed & ~edge_pulse & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (edge_pulse) begin
      remain <= dly;
      armed  <= 1'b1;
    end else if (strobe && armed) begin
      if (at_zero) armed  <= 1'b0;
      else         remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int STAT_W   = 8,
  parameter int MARK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              hit,
  output logic              vld_out,
  output logic [STAT_W-1:0] stat_out
);
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt           = stat_in;
    stat_nxt[MARK_BIT] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out  <= 1'b0;
      stat_out <= '0;
    end else begin
      vld_out  <= strobe;
      stat_out <= strobe ? stat_nxt : '0;
    end
  end
endmodule

// File: rtl/evt_marker_top.sv
module evt_marker_top
  import evt_marker_pkg::*;
#(
  parameter int DW = DLY_W,
  parameter int AW = ADDR_W,
  parameter int SW = STAT_W,
  parameter int MB = MARK_BIT,
  parameter int NS = SYNC_STAGES,
  parameter logic [AW-1:0] RA = DLY_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          smp_valid,
  input  logic [SW-1:0] stat_in,
  output logic          vld_out,
  output logic [SW-1:0] stat_out
);
  logic          edge_det;
  logic [DW-1:0] dly_q;
  logic          mark_hit;

  evt_sync #(.STAGES(NS)) u_sync (
    .clk(clk), .rst(rst), .async_in(evt_in), .edge_pulse(edge_det)
  );

  dly_cfg #(.ADDR_W(AW), .DLY_W(DW), .REG_ADDR(RA)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .dly_q(dly_q)
  );

  dly_counter #(.DLY_W(DW)) u_cnt (
    .clk(clk), .rst(rst), .edge_pulse(edge_det), .strobe(smp_valid),
    .dly(dly_q), .hit(mark_hit)
  );

  out_stage #(.STAT_W(SW), .MARK_BIT(MB)) u_out (
    .clk(clk), .rst(rst), .strobe(smp_valid), .stat_in(stat_in),
    .hit(mark_hit), .vld_out(vld_out), .stat_out(stat_out)
  );
endmodule

// File: rtl/evt_marker_chk.sv
module evt_marker_chk #(
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int MB = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          edge_det,
  input logic [DW-1:0] dly_q,
  input logic          smp_valid,
  input logic [SW-1:0] stat_in,
  input logic          vld_out,
  input logic [SW-1:0] stat_out
);
  logic [DW:0]   seen;
  logic [DW-1:0] lat_dly;
  logic          armed_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= '0;
      lat_dly   <= '0;
      armed_ref <= 1'b0;
    end else if (edge_det) begin
      seen      <= '0;
      lat_dly   <= dly_q;
      armed_ref <= 1'b1;
    end else if (smp_valid && armed_ref) begin
      seen <= seen + 1'b1;
      if (seen == {1'b0, lat_dly}) armed_ref <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!vld_out && stat_out == '0));

  // R7
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> vld_out);

  // R7
  pass_bits_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (stat_out[MB-1:0] == $past(stat_in[MB-1:0])));

  // R4
  mark_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    stat_out[MB] |-> vld_out);

  // R3
  mark_index_chk: assert property (@(posedge clk) disable iff (rst)
    stat_out[MB] |-> (seen == {1'b0, lat_dly} + 1'b1));

  // R4
  mark_single_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_out[MB] && !edge_det) |=> !stat_out[MB] || edge_det);
endmodule

bind evt_marker_top evt_marker_chk #(.DW(DW), .SW(SW), .MB(MB)) u_chk (
  .clk(clk), .rst(rst), .edge_det(edge_det), .dly_q(dly_q),
  .smp_valid(smp_valid), .stat_in(stat_in), .vld_out(vld_out),
  .stat_out(stat_out)
);

// File: tb/evt_marker_top_bench.sv
module evt_marker_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        evt_in;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        smp_valid;
  logic [7:0]  stat_in;
  logic        vld_out;
  logic [7:0]  stat_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  evt_marker_top u_evt_marker_top (
    .clk(clk), .rst(rst), .evt_in(evt_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smp_valid(smp_valid),
    .stat_in(stat_in), .vld_out(vld_out), .stat_out(stat_out)
  );

  // {delay[31:16], strobes observed[15:0]}
  localparam int NVEC = 5;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd0,   16'd4},
    {16'd1,   16'd5},
    {16'd3,   16'd8},
    {16'd7,   16'd12},
    {16'd300, 16'd304}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    evt_in = 1'b1;
    repeat (6) @(negedge clk);
    evt_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // one strobe; returns marker bit, checks pass-through (R7)
  task automatic strobe(input logic [7:0] val, output bit mk);
    @(negedge clk);
    smp_valid = 1'b1; stat_in = val;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(vld_out == 1'b1, "R7 vld_out", vld_out, 1);
    chk(stat_out[6:0] == val[6:0], "R7 low bits", stat_out[6:0], val[6:0]);
    mk = stat_out[7];
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit mk;
    int marks;
    int pos;
    rst = 1'b1; evt_in = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; smp_valid = 1'b0; stat_in = '0;
    repeat (3) @(negedge clk);
    chk(vld_out == 1'b0 && stat_out == 8'h00, "R1 reset outputs", stat_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(vld_out == 1'b0 && stat_out == 8'h00, "R1 after reset", stat_out, 0);

    // R1: delay register resets to zero -> marker on first strobe
    pulse_evt();
    strobe(8'h81, mk);
    chk(mk == 1'b1, "R1 default delay zero", mk, 1);

    // Table walk: R2 R3 R4 R7 (stat_in bit7 held high, must be ignored)
    for (int v = 0; v < NVEC; v++) begin
      wr(8'h29, VEC[v][31:16]);
      pulse_evt();
      marks = 0; pos = -1;
      for (int i = 0; i < int'(VEC[v][15:0]); i++) begin
        strobe(8'h80 | 8'(i), mk);
        if (mk) begin marks++; pos = i; end
        chk(mk == (i == int'(VEC[v][31:16])), "R3 marker index", mk, (i == int'(VEC[v][31:16])));
      end
      chk(marks == 1, "R4 single marker", marks, 1);
      chk(pos == int'(VEC[v][31:16]), "R3 marker position", pos, VEC[v][31:16]);
    end

    // R2: held-high level and falling edge give no marker
    wr(8'h29, 16'd0);
    @(negedge clk); evt_in = 1'b1;
    repeat (6) @(negedge clk);
    strobe(8'h05, mk);
    chk(mk == 1'b1, "R2 rising edge marks", mk, 1);
    marks = 0;
    for (int i = 0; i < 4; i++) begin strobe(8'h05, mk); marks += mk; end
    chk(marks == 0, "R2 level ignored", marks, 0);
    @(negedge clk); evt_in = 1'b0;
    repeat (6) @(negedge clk);
    marks = 0;
    for (int i = 0; i < 4; i++) begin strobe(8'h05, mk); marks += mk; end
    chk(marks == 0, "R2 falling edge ignored", marks, 0);

    // R5: write to another address leaves delay at 2
    wr(8'h29, 16'd2);
    wr(8'h28, 16'd6);
    pulse_evt();
    pos = -1;
    for (int i = 0; i < 9; i++) begin strobe(8'h00, mk); if (mk) pos = i; end
    chk(pos == 2, "R5 stray address ignored", pos, 2);

    // R6: restart mid-count
    wr(8'h29, 16'd5);
    pulse_evt();
    marks = 0;
    for (int i = 0; i < 2; i++) begin strobe(8'h11, mk); marks += mk; end
    pulse_evt();
    pos = -1;
    for (int i = 0; i < 10; i++) begin strobe(8'h11, mk); marks += mk; if (mk) pos = i; end
    chk(marks == 1, "R6 one marker after restart", marks, 1);
    chk(pos == 5, "R6 restart index", pos, 5);

    // R1: reset discards pending marker and clears delay
    wr(8'h29, 16'd3);
    pulse_evt();
    strobe(8'h00, mk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    marks = 0;
    for (int i = 0; i < 6; i++) begin strobe(8'h00, mk); marks += mk; end
    chk(marks == 0, "R1 pending cleared", marks, 0);
    pulse_evt();
    strobe(8'h00, mk);
    chk(mk == 1'b1, "R1 delay cleared", mk, 1);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule